// File: doc/BRIEF.md
# I2C Bus Clock and Condition Timer

This block turns a fast system clock into the SCL waveform of an I2C controller and tells the data path when to move SDA and when to sample it. Two 16-bit divider fields set the time base. One sets the low phase of SCL and the other sets the high phase. Each phase lasts eight input clocks per divider step, plus one step.

A byte sequencer drives the block one bus operation at a time: START, a single data bit, repeated START, and STOP. For each operation the block drives the open-drain pull enables for SCL and SDA. It emits a data-change strobe halfway through every low phase and a sample strobe halfway through the high phase of a data bit. It pulses a done flag on the clock edge that ends the operation.

Between operations the block parks with SCL held low, except after a STOP, when it goes idle with both lines released. The sequencer waits for the done pulse before it issues the next request.

Top module: `i2c_scl_timer`

## Requirements
- R1: While reset is high, and on the first cycle after it, both pull enables, both strobes and the done flag are 0.
- R2: Bits 31:16 of the divider input give the high-phase divider H, and bits 15:0 give the low-phase divider L.
- R3: The low phase of a bus operation lasts (L+1)*8 clocks, counted from the edge that accepts the request to the edge that releases SCL (scl_pull 1 to 0).
- R4: An ordinary high phase lasts (H+1)*8 clocks, from the release of SCL to SCL being pulled low again.
- R5: The change strobe pulses (L+1)*4 clocks into every low phase. On that same edge the data bit is applied: for op code 1 (bit), sda_pull becomes the inverse of cmd_bit.
- R6: For a data bit, the sample strobe pulses (H+1)*4 clocks after SCL is released, while SCL is released.
- R7: START (op code 0) is accepted only when idle. SDA is pulled low on the accept edge with SCL released, and SCL is pulled low (H+1)*8 clocks later.
- R8: Repeated START (op code 2) releases SDA at the change point. SDA is then pulled low 7*(H+1) clocks after SCL is released, and SCL stays released for 2*(H+1)*8 clocks.
- R9: STOP (op code 3) pulls SDA low at the change point. SDA is released (H+1)*8 clocks after SCL is released, and the block then goes idle.
- R10: A change of the divider input during a phase does not alter that phase. The next phase uses the new value.
- R11: A request is ignored, with no line change and no done pulse, if it is anything other than START while idle, START while parked, or any request while an operation is running.
- R12: op_done pulses for exactly one cycle, on the edge that makes the operation's final line change.
- R13: When idle, both pull enables are 0 and the phase counter is held at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| div_cfg | input | 32 | High-phase divider in 31:16, low-phase divider in 15:0 |
| cmd_req | input | 1 | Request strobe for a bus operation |
| cmd_op | input | 2 | 0 START, 1 bit, 2 repeated START, 3 STOP |
| cmd_bit | input | 1 | Data bit for op 1 (1 leaves SDA released) |
| scl_pull | output | 1 | 1 pulls SCL low |
| sda_pull | output | 1 | 1 pulls SDA low |
| chg_stb | output | 1 | Data-change point in the low phase |
| smp_stb | output | 1 | Data-sample point in the high phase |
| op_done | output | 1 | Operation finished |

## Verification
The assertions assume that the sequencer only presents a request when the block can accept it, or else accepts that it will be dropped. They also assume that SDA never moves while SCL is released except as part of a START, repeated START or STOP.

The stimulus waits for each done pulse before it issues the next operation. It issues out-of-place requests only where it deliberately tests that they are dropped. It changes the divider input only during the low phase, to test that the current phase keeps its latched value.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;

  typedef enum logic [1:0] {
    OP_START  = 2'd0,
    OP_BIT    = 2'd1,
    OP_RSTART = 2'd2,
    OP_STOP   = 2'd3
  } bus_op_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PARK  = 3'd1,
    ST_STH   = 3'd2,
    ST_LOW   = 3'd3,
    ST_HIGH  = 3'd4
  } tstate_e;

endpackage

// File: rtl/i2ct_phase_tmr.sv
module i2ct_phase_tmr #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             clr,
  input  logic             dbl_in,
  input  logic [DIV_W-1:0] div_in,
  output logic [DIV_W+4:0] cnt,
  output logic             at_end,
  output logic             at_half,
  output logic             at_7_8
);
  localparam int CW = DIV_W + 5;

  logic [DIV_W-1:0] dv_q;
  logic             dbl_q;
  logic [CW-1:0]    unit, len, half, sev;

  always_comb begin
    unit = CW'(dv_q) + CW'(1);
    half = unit << 2;
    sev  = (unit << 3) - unit;
    len  = dbl_q ? (unit << 4) : (unit << 3);
  end

  assign at_end  = (cnt == len - CW'(1));
  assign at_half = (cnt == half - CW'(1));
  assign at_7_8  = (cnt == sev - CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      dv_q  <= '0;
      dbl_q <= 1'b0;
    end else if (load) begin
      cnt   <= '0;
      dv_q  <= div_in;
      dbl_q <= dbl_in;
    end else if (clr) begin
      cnt   <= '0;
    end else begin
      cnt   <= cnt + CW'(1);
    end
  end
endmodule

// File: rtl/i2ct_cmd_gate.sv
module i2ct_cmd_gate
  import i2ct_pkg::*;
(
  input  tstate_e st,
  input  logic    cmd_req,
  input  bus_op_e cmd_op,
  output logic    accept
);
  always_comb begin
    accept = 1'b0;
    if (cmd_req) begin
      unique case (st)
        ST_IDLE: accept = (cmd_op == OP_START);
        ST_PARK: accept = (cmd_op != OP_START);
        default: accept = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/i2ct_seq.sv
module i2ct_seq
  import i2ct_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    accept,
  input  bus_op_e cmd_op,
  input  logic    cmd_bit,
  input  logic    at_end,
  input  logic    at_half,
  input  logic    at_7_8,
  output logic    tmr_load,
  output logic    tmr_clr,
  output logic    tmr_dbl,
  output logic    tmr_sel_hi,
  output tstate_e st,
  output bus_op_e op_q,
  output logic    scl_oe,
  output logic    sda_oe,
  output logic    chg,
  output logic    smp,
  output logic    done
);
  logic bit_q;

  always_comb begin
    tmr_load   = 1'b0;
    tmr_clr    = 1'b0;
    tmr_dbl    = 1'b0;
    tmr_sel_hi = 1'b0;
    unique case (st)
      ST_IDLE: begin
        if (accept) begin
          tmr_load   = 1'b1;
          tmr_sel_hi = 1'b1;
        end else begin
          tmr_clr    = 1'b1;
        end
      end
      ST_PARK: begin
        if (accept) tmr_load = 1'b1;
        else        tmr_clr  = 1'b1;
      end
      ST_LOW: begin
        if (at_end) begin
          tmr_load   = 1'b1;
          tmr_sel_hi = 1'b1;
          tmr_dbl    = (op_q == OP_RSTART);
        end
      end
      default: tmr_clr = at_end;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      op_q   <= OP_START;
      bit_q  <= 1'b1;
      scl_oe <= 1'b0;
      sda_oe <= 1'b0;
      chg    <= 1'b0;
      smp    <= 1'b0;
      done   <= 1'b0;
    end else begin
      chg  <= 1'b0;
      smp  <= 1'b0;
      done <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (accept) begin
            op_q   <= cmd_op;
            sda_oe <= 1'b1;
            st     <= ST_STH;
          end
        end
        ST_PARK: begin
          if (accept) begin
            op_q  <= cmd_op;
            bit_q <= cmd_bit;
            st    <= ST_LOW;
          end
        end
        ST_STH: begin
          if (at_end) begin
            scl_oe <= 1'b1;
            done   <= 1'b1;
            st     <= ST_PARK;
          end
        end
        ST_LOW: begin
          if (at_half) begin
            chg <= 1'b1;
            unique case (op_q)
              OP_BIT:  sda_oe <= ~bit_q;
              OP_STOP: sda_oe <= 1'b1;
              default: sda_oe <= 1'b0;
            endcase
          end
          if (at_end) begin
            scl_oe <= 1'b0;
            st     <= ST_HIGH;
          end
        end
        ST_HIGH: begin
          if (at_half && op_q == OP_BIT) smp <= 1'b1;
          if (at_7_8 && op_q == OP_RSTART) sda_oe <= 1'b1;
          if (at_end) begin
            done <= 1'b1;
            if (op_q == OP_STOP) begin
              sda_oe <= 1'b0;
              st     <= ST_IDLE;
            end else begin
              scl_oe <= 1'b1;
              st     <= ST_PARK;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_scl_timer.sv
module i2c_scl_timer
  import i2ct_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [2*DIV_W-1:0] div_cfg,
  input  logic               cmd_req,
  input  logic [1:0]         cmd_op,
  input  logic               cmd_bit,
  output logic               scl_pull,
  output logic               sda_pull,
  output logic               chg_stb,
  output logic               smp_stb,
  output logic               op_done
);
  localparam int CW = DIV_W + 5;

  tstate_e          st;
  bus_op_e          op_cur;
  logic             accept;
  logic             tmr_load, tmr_clr, tmr_dbl, tmr_sel_hi;
  logic             at_end, at_half, at_7_8;
  logic [CW-1:0]    tcnt;
  logic [DIV_W-1:0] div_hi, div_lo, div_sel;

  assign div_hi  = div_cfg[2*DIV_W-1:DIV_W];
  assign div_lo  = div_cfg[DIV_W-1:0];
  assign div_sel = tmr_sel_hi ? div_hi : div_lo;

  i2ct_cmd_gate u_gate (
    .st      (st),
    .cmd_req (cmd_req),
    .cmd_op  (bus_op_e'(cmd_op)),
    .accept  (accept)
  );

  i2ct_phase_tmr #(.DIV_W(DIV_W)) u_tmr (
    .clk     (clk),
    .rst     (rst),
    .load    (tmr_load),
    .clr     (tmr_clr),
    .dbl_in  (tmr_dbl),
    .div_in  (div_sel),
    .cnt     (tcnt),
    .at_end  (at_end),
    .at_half (at_half),
    .at_7_8  (at_7_8)
  );

  i2ct_seq u_seq (
    .clk        (clk),
    .rst        (rst),
    .accept     (accept),
    .cmd_op     (bus_op_e'(cmd_op)),
    .cmd_bit    (cmd_bit),
    .at_end     (at_end),
    .at_half    (at_half),
    .at_7_8     (at_7_8),
    .tmr_load   (tmr_load),
    .tmr_clr    (tmr_clr),
    .tmr_dbl    (tmr_dbl),
    .tmr_sel_hi (tmr_sel_hi),
    .st         (st),
    .op_q       (op_cur),
    .scl_oe     (scl_pull),
    .sda_oe     (sda_pull),
    .chg        (chg_stb),
    .smp        (smp_stb),
    .done       (op_done)
  );
endmodule

// File: rtl/i2ct_chk.sv
module i2ct_chk
  import i2ct_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             scl_oe,
  input logic             sda_oe,
  input logic             chg,
  input logic             smp,
  input logic             done,
  input tstate_e          st,
  input bus_op_e          op,
  input logic [DIV_W+4:0] cnt
);
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!scl_oe && !sda_oe && !done && !chg && !smp));

  a_r13_idle_released: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE) |-> (!scl_oe && !sda_oe && cnt == '0));

  a_r12_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r5_chg_in_low: assert property (@(posedge clk) disable iff (rst)
    chg |-> scl_oe);

  a_r6_smp_in_high: assert property (@(posedge clk) disable iff (rst)
    smp |-> !scl_oe);

  // R7 R8 R9: SDA moves with SCL released only for a bus condition
  a_r9_sda_cond_only: assert property (@(posedge clk) disable iff (rst)
    (!scl_oe && !$past(scl_oe) && !$stable(sda_oe)) |-> (op != OP_BIT));
endmodule

bind i2c_scl_timer i2ct_chk #(.DIV_W(DIV_W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .scl_oe (scl_pull),
  .sda_oe (sda_pull),
  .chg    (chg_stb),
  .smp    (smp_stb),
  .done   (op_done),
  .st     (st),
  .op     (op_cur),
  .cnt    (tcnt)
);

// File: tb/sim_i2c_scl_timer.sv
module sim_i2c_scl_timer;
  timeunit 1ns;
  timeprecision 100ps;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] div_cfg = '0;
  logic        cmd_req = 1'b0;
  logic [1:0]  cmd_op = 2'd0;
  logic        cmd_bit = 1'b0;
  logic        scl_pull, sda_pull, chg_stb, smp_stb, op_done;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int t_acc = 0;
  int t_scl_fall = -1, t_scl_rise = -1, t_sda_fall = -1, t_sda_rise = -1;
  int t_chg = -1, t_smp = -1, t_done = -1;
  logic scl_p = 1'b0, sda_p = 1'b0;

  // {H, L, bit}
  localparam logic [32:0] VEC [0:5] = '{
    {16'd0, 16'd0, 1'b1},
    {16'd1, 16'd2, 1'b0},
    {16'd3, 16'd1, 1'b1},
    {16'd2, 16'd5, 1'b0},
    {16'd6, 16'd3, 1'b1},
    {16'd0, 16'd7, 1'b0}
  };

  i2c_scl_timer u0 (
    .clk(clk), .rst(rst), .div_cfg(div_cfg), .cmd_req(cmd_req),
    .cmd_op(cmd_op), .cmd_bit(cmd_bit), .scl_pull(scl_pull),
    .sda_pull(sda_pull), .chg_stb(chg_stb), .smp_stb(smp_stb),
    .op_done(op_done)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst) begin
      if (scl_pull && !scl_p) t_scl_fall = cyc;
      if (!scl_pull && scl_p) t_scl_rise = cyc;
      if (sda_pull && !sda_p) t_sda_fall = cyc;
      if (!sda_pull && sda_p) t_sda_rise = cyc;
      if (chg_stb) t_chg = cyc;
      if (smp_stb) t_smp = cyc;
      if (op_done) t_done = cyc;
    end
    scl_p = scl_pull;
    sda_p = sda_pull;
  end

  task automatic chk(input int got, input int exp, input string tag);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic issue(input logic [1:0] op, input logic b);
    @(negedge clk);
    cmd_req = 1'b1;
    cmd_op  = op;
    cmd_bit = b;
    @(negedge clk);
    t_acc   = cyc;
    cmd_req = 1'b0;
  endtask

  task automatic wait_done();
    do begin
      @(negedge clk);
      #1;
    end while (t_done <= t_acc);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int a, d0, hv, lv, lenl, lenh;
    logic bv;
    repeat (3) @(negedge clk);
    chk(int'(scl_pull), 0, "R1 scl in reset");
    chk(int'(sda_pull), 0, "R1 sda in reset");
    chk(int'(op_done | chg_stb | smp_stb), 0, "R1 strobes in reset");
    rst = 1'b0;

    for (int i = 0; i < 6; i++) begin
      hv = int'(VEC[i][32:17]);
      lv = int'(VEC[i][16:1]);
      bv = VEC[i][0];
      lenl = (lv + 1) * 8;
      lenh = (hv + 1) * 8;
      div_cfg = {VEC[i][32:17], VEC[i][16:1]};
      // START
      issue(2'd0, 1'b0); wait_done();
      chk(t_sda_fall, t_acc, "R7 sda falls on accept");
      chk(t_scl_fall, t_acc + lenh, "R7 scl falls after high time");
      chk(t_done, t_acc + lenh, "R12 done at start end");
      // data bit
      issue(2'd1, bv); wait_done();
      chk(t_chg, t_acc + (lv + 1) * 4, "R5 change strobe");
      chk(int'(sda_pull), int'(!bv), "R5 data value");
      chk(t_scl_rise, t_acc + lenl, "R3 low length");
      chk(t_smp, t_acc + lenl + (hv + 1) * 4, "R6 sample strobe");
      chk(t_scl_fall, t_acc + lenl + lenh, "R4 high length");
      // repeated START
      issue(2'd2, 1'b0); wait_done();
      if (!bv) chk(t_sda_rise, t_acc + (lv + 1) * 4, "R8 sda released mid low");
      chk(t_scl_rise, t_acc + lenl, "R8 scl rise");
      chk(t_sda_fall, t_acc + lenl + 7 * (hv + 1), "R8 sda at 7/8");
      chk(t_scl_fall, t_acc + lenl + 2 * lenh, "R8 doubled high");
      // inverse bit
      issue(2'd1, !bv); wait_done();
      chk(t_done, t_acc + lenl + lenh, "R12 done at bit end");
      // STOP
      issue(2'd3, 1'b0); wait_done();
      if (!bv) chk(t_sda_fall, t_acc + (lv + 1) * 4, "R9 sda low mid low");
      chk(t_scl_rise, t_acc + lenl, "R9 scl rise");
      chk(t_sda_rise, t_acc + lenl + lenh, "R9 sda release");
      chk(int'(scl_pull | sda_pull), 0, "R13 released after stop");
    end

    // R11 requests ignored while idle
    div_cfg = {16'd2, 16'd3};
    d0 = t_done;
    issue(2'd1, 1'b0); issue(2'd3, 1'b0); issue(2'd2, 1'b0);
    repeat (40) @(negedge clk);
    chk(int'(scl_pull | sda_pull), 0, "R11 idle ignores non-start");
    chk(t_done, d0, "R11 no done while idle");
    chk(int'(scl_pull | sda_pull), 0, "R13 idle stays released");

    // R11 START ignored while parked
    issue(2'd0, 1'b0); wait_done();
    d0 = t_done;
    issue(2'd0, 1'b0);
    repeat (40) @(negedge clk);
    chk(int'(scl_pull), 1, "R11 parked scl held");
    chk(t_done, d0, "R11 start ignored while parked");

    // R11 request during a running bit
    issue(2'd1, 1'b1);
    a = t_acc;
    repeat (5) @(negedge clk);
    cmd_req = 1'b1; cmd_op = 2'd3;
    @(negedge clk);
    cmd_req = 1'b0;
    t_acc = a;
    wait_done();
    chk(t_done, a + 32 + 24, "R11 busy request dropped");
    repeat (20) @(negedge clk);
    chk(int'(scl_pull), 1, "R11 still parked");

    // R10 divider change within a low phase; R2 field split
    issue(2'd1, 1'b0);
    a = t_acc;
    repeat (5) @(negedge clk);
    div_cfg = {16'd5, 16'd20};
    wait_done();
    chk(t_scl_rise, a + 32, "R10 current low phase kept");
    chk(t_smp, a + 32 + 24, "R2 new high divider used");
    chk(t_done, a + 32 + 48, "R10 next phase uses new value");

    // R3 large low divider
    div_cfg = {16'd3, 16'h0FFF};
    issue(2'd1, 1'b1); wait_done();
    chk(t_scl_rise, t_acc + 32768, "R3 large low divider");
    chk(t_done, t_acc + 32768 + 32, "R4 high after large low");

    issue(2'd3, 1'b0); wait_done();
    chk(int'(scl_pull | sda_pull), 0, "R9 idle after final stop");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule